// File: doc/BRIEF.md
# Multi-Format Integer Add/Subtract Unit

This block performs addition, subtraction or negation on two N-bit operands and reads them in one of four number formats chosen per operation: plain unsigned binary, sign-magnitude, one's complement and two's complement. Each format has its own datapath. Two's complement uses a single carry chain. One's complement folds the carry out of the top bit back into the sum. Sign-magnitude compares the magnitudes and subtracts the smaller from the larger when the effective signs differ. Each format also has its own overflow rule.

A request is presented with `in_vld` high, together with the operands, the operation code and the format code. On the next rising clock edge the result, a sign bit, a signed-overflow flag, an unsigned out-of-range flag and an error flag are captured, and `out_vld` rises for one cycle. The registered outputs keep their values while no request is presented. Negative zero never appears at the output: both sign-magnitude and one's complement return the single all-zero pattern for a zero result.

Top module: `mfmt_arith`

## Requirements
- R1: While `rst_n` is low at a rising edge, all outputs are cleared to zero. They stay zero until the first accepted request.
- R2: A request sampled with `in_vld` high sets `out_vld` high after that edge, and the new results are visible from then on. With `in_vld` low, `out_vld` is low after the edge and the result and flags keep their previous values.
- R3: Format code 0 (unsigned), op 0 (add) gives (A+B) mod 2^N with `oor` equal to the carry out. Op 1 (subtract) gives (A-B) mod 2^N with `oor` set exactly when A < B. `ovf` is 0 in this format.
- R4: Format code 0 with op 2 (negate) is unsupported. It returns A unchanged, raises `err`, and leaves `oor` and `ovf` at 0.
- R5: Format code 3 (two's complement), ops 0/1/2 (A+B, A-B, -A) return the true result mod 2^N. `ovf` is set exactly when the integer result lies outside -2^(N-1)..2^(N-1)-1; for example, negating the pattern 1000..0 overflows.
- R6: Format code 2 (one's complement), ops 0/1, adds with end-around carry. A negative value v is encoded as the bitwise inverse of |v|. When the integer result lies within -(2^(N-1)-1)..2^(N-1)-1 it is returned in that encoding; otherwise `ovf` is set and the result bits are not defined.
- R7: Format code 2 with op 2 inverts every bit of A, after which R10 applies, and never sets `ovf`.
- R8: Format code 1 (sign-magnitude: top bit is the sign, 1 meaning negative; the rest is the magnitude), ops 0/1. Subtraction flips the sign of B, then both ops add. With equal effective signs the magnitudes are added and the sign kept. With different signs the smaller magnitude is taken from the larger and the result carries the sign of the larger. `ovf` is set only on a magnitude carry with equal signs, and then the result bits are not defined.
- R9: Format code 1 with op 2 flips only the sign bit of A, after which R10 applies, and never sets `ovf`.
- R10: In formats 1 and 2, a zero result is always output as all zeros, never as the negative-zero pattern.
- R11: Op code 3 is reserved in every format. It returns A unchanged with `err` set and `ovf` and `oor` clear.
- R12: `sign` equals the top bit of the result in formats 1, 2 and 3 and is 0 in format 0. `oor` is 0 in formats 1 to 3, and `err` is 0 for every supported operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe; operands are sampled at the edge while high |
| fmt_i | input | 2 | Number format: 0 unsigned, 1 sign-magnitude, 2 one's complement, 3 two's complement |
| op_i | input | 2 | Operation: 0 add, 1 subtract, 2 negate A, 3 reserved |
| a_i | input | N | First operand |
| b_i | input | N | Second operand (ignored for negate) |
| out_vld | output | 1 | High for the cycle after an accepted request |
| res_o | output | N | Registered result |
| sign_o | output | 1 | Sign of the result in signed formats |
| ovf_o | output | 1 | Signed overflow |
| oor_o | output | 1 | Unsigned carry/borrow out of range |
| err_o | output | 1 | Unsupported or reserved operation |

## Verification
Every result and flag passes through exactly one register. A request driven before edge k is therefore due on the outputs just after edge k, together with `out_vld`, and it must still be there after later edges that see `in_vld` low. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, so each check looks at the single register stage half a cycle after it loaded. The hold check drops `in_vld`, changes the operands and reads again one falling edge later, expecting the old values. Expected values come from integer arithmetic on decoded operand values, swept exhaustively at N=4 and with random operands at N=8.

// File: rtl/mfmt_pkg.sv
package mfmt_pkg;

    typedef enum logic [1:0] {
        FMT_UNS  = 2'd0,
        FMT_SMAG = 2'd1,
        FMT_ONES = 2'd2,
        FMT_TWOS = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_NEG = 2'd2,
        OP_RSV = 2'd3
    } op_e;

endpackage

// File: rtl/mfmt_radd.sv
// Ripple-carry adder that also exposes the carry into its top bit.
module mfmt_radd #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ctop_o
);
    logic [W:0] carry;

    assign carry[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]   = x_i[i] ^ y_i[i] ^ carry[i];
        assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
    end

    assign cout_o = carry[W];
    assign ctop_o = carry[W-1];
endmodule

// File: rtl/mfmt_uns_unit.sv
// Unsigned add / subtract with carry or borrow as out-of-range.
module mfmt_uns_unit
    import mfmt_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  op_e          op_i,
    output logic [N-1:0] res_o,
    output logic         oor_o,
    output logic         err_o
);
    logic         is_sub;
    logic [N-1:0] y_opd;
    logic [N-1:0] sum;
    logic         cout;
    logic         unused_ctop;

    assign is_sub = (op_i == OP_SUB);
    assign y_opd  = is_sub ? ~b_i : b_i;

    mfmt_radd #(.W(N)) u_add (
        .x_i    (a_i),
        .y_i    (y_opd),
        .cin_i  (is_sub),
        .sum_o  (sum),
        .cout_o (cout),
        .ctop_o (unused_ctop)
    );

    always_comb begin
        res_o = sum;
        oor_o = is_sub ? ~cout : cout;
        err_o = 1'b0;
        if (op_i == OP_NEG || op_i == OP_RSV) begin
            res_o = a_i;
            oor_o = 1'b0;
            err_o = 1'b1;
        end
    end
endmodule

// File: rtl/mfmt_comp_unit.sv
// Complement-format datapath; ONES picks end-around carry over +1 negation.
module mfmt_comp_unit
    import mfmt_pkg::*;
#(
    parameter int N    = 8,
    parameter bit ONES = 1'b0
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  op_e          op_i,
    output logic [N-1:0] res_o,
    output logic         ovf_o
);
    localparam logic INC = ONES ? 1'b0 : 1'b1;

    logic [N-1:0] x_opd;
    logic [N-1:0] y_opd;
    logic         cin;
    logic [N-1:0] sum1;
    logic         cout1;
    logic         ctop1;

    always_comb begin
        unique case (op_i)
            OP_ADD: begin x_opd = a_i;  y_opd = b_i;  cin = 1'b0; end
            OP_SUB: begin x_opd = a_i;  y_opd = ~b_i; cin = INC;  end
            default: begin x_opd = ~a_i; y_opd = '0;  cin = INC;  end
        endcase
    end

    mfmt_radd #(.W(N)) u_main (
        .x_i    (x_opd),
        .y_i    (y_opd),
        .cin_i  (cin),
        .sum_o  (sum1),
        .cout_o (cout1),
        .ctop_o (ctop1)
    );

    if (ONES) begin : g_ones
        logic [N-1:0] sum2;
        logic         unused_c2;
        logic         unused_t2;
        logic         unused_t1;

        assign unused_t1 = ctop1;

        mfmt_radd #(.W(N)) u_wrap (
            .x_i    (sum1),
            .y_i    ({N{1'b0}}),
            .cin_i  (cout1),
            .sum_o  (sum2),
            .cout_o (unused_c2),
            .ctop_o (unused_t2)
        );

        // Sign comparison after the wrap stays correct when an operand is -0.
        assign ovf_o = (x_opd[N-1] == y_opd[N-1]) && (sum2[N-1] != x_opd[N-1]);
        assign res_o = (&sum2) ? '0 : sum2;
    end else begin : g_twos
        assign ovf_o = cout1 ^ ctop1;
        assign res_o = sum1;
    end
endmodule

// File: rtl/mfmt_smag_unit.sv
// Sign-magnitude datapath: add magnitudes, or compare and subtract.
module mfmt_smag_unit
    import mfmt_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  op_e          op_i,
    output logic [N-1:0] res_o,
    output logic         ovf_o
);
    localparam int M = N - 1;

    logic         sa;
    logic         sb;
    logic [M-1:0] ma;
    logic [M-1:0] mb;
    logic [M-1:0] msum;
    logic         mcar;
    logic [M-1:0] mdif;
    logic         a_ge_b;
    logic [M-1:0] mrev;
    logic         sgn;
    logic [M-1:0] mag;
    logic         unused_t0;
    logic         unused_t1;
    logic         unused_t2;
    logic         unused_c2;

    assign sa = a_i[N-1];
    assign ma = a_i[M-1:0];
    assign sb = b_i[N-1] ^ (op_i == OP_SUB);
    assign mb = b_i[M-1:0];

    mfmt_radd #(.W(M)) u_sum (
        .x_i (ma), .y_i (mb), .cin_i (1'b0),
        .sum_o (msum), .cout_o (mcar), .ctop_o (unused_t0)
    );

    mfmt_radd #(.W(M)) u_dif (
        .x_i (ma), .y_i (~mb), .cin_i (1'b1),
        .sum_o (mdif), .cout_o (a_ge_b), .ctop_o (unused_t1)
    );

    mfmt_radd #(.W(M)) u_rev (
        .x_i (~mdif), .y_i ({M{1'b0}}), .cin_i (1'b1),
        .sum_o (mrev), .cout_o (unused_c2), .ctop_o (unused_t2)
    );

    always_comb begin
        ovf_o = 1'b0;
        if (op_i == OP_NEG || op_i == OP_RSV) begin
            sgn = ~sa;
            mag = ma;
        end else if (sa == sb) begin
            sgn   = sa;
            mag   = msum;
            ovf_o = mcar;
        end else if (a_ge_b) begin
            sgn = sa;
            mag = mdif;
        end else begin
            sgn = sb;
            mag = mrev;
        end
        if (mag == '0) begin
            sgn = 1'b0;
        end
        res_o = {sgn, mag};
    end
endmodule

// File: rtl/mfmt_arith.sv
module mfmt_arith
    import mfmt_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [1:0]   fmt_i,
    input  logic [1:0]   op_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic         out_vld,
    output logic [N-1:0] res_o,
    output logic         sign_o,
    output logic         ovf_o,
    output logic         oor_o,
    output logic         err_o
);
    localparam logic [N-1:0] MINPAT = {1'b1, {(N-1){1'b0}}};

    typedef struct packed {
        logic         vld;
        logic [N-1:0] res;
        logic         sign;
        logic         ovf;
        logic         oor;
        logic         err;
    } out_t;

    fmt_e fmt;
    op_e  op;
    out_t st_d;
    out_t st_q;

    logic [N-1:0] u_res;
    logic         u_oor;
    logic         u_err;
    logic [N-1:0] sm_res;
    logic         sm_ovf;
    logic [N-1:0] oc_res;
    logic         oc_ovf;
    logic [N-1:0] tc_res;
    logic         tc_ovf;

    assign fmt = fmt_e'(fmt_i);
    assign op  = op_e'(op_i);

    mfmt_uns_unit #(.N(N)) u_uns (
        .a_i (a_i), .b_i (b_i), .op_i (op),
        .res_o (u_res), .oor_o (u_oor), .err_o (u_err)
    );

    mfmt_smag_unit #(.N(N)) u_smag (
        .a_i (a_i), .b_i (b_i), .op_i (op),
        .res_o (sm_res), .ovf_o (sm_ovf)
    );

    mfmt_comp_unit #(.N(N), .ONES(1'b1)) u_ones (
        .a_i (a_i), .b_i (b_i), .op_i (op),
        .res_o (oc_res), .ovf_o (oc_ovf)
    );

    mfmt_comp_unit #(.N(N), .ONES(1'b0)) u_twos (
        .a_i (a_i), .b_i (b_i), .op_i (op),
        .res_o (tc_res), .ovf_o (tc_ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.ovf = 1'b0;
            st_d.oor = 1'b0;
            st_d.err = 1'b0;
            unique case (fmt)
                FMT_UNS:  begin st_d.res = u_res;  st_d.oor = u_oor;  st_d.err = u_err; end
                FMT_SMAG: begin st_d.res = sm_res; st_d.ovf = sm_ovf; end
                FMT_ONES: begin st_d.res = oc_res; st_d.ovf = oc_ovf; end
                default:  begin st_d.res = tc_res; st_d.ovf = tc_ovf; end
            endcase
            if (op == OP_RSV) begin
                st_d.res = a_i;
                st_d.ovf = 1'b0;
                st_d.oor = 1'b0;
                st_d.err = 1'b1;
            end
            st_d.sign = (fmt != FMT_UNS) && st_d.res[N-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign res_o   = st_q.res;
    assign sign_o  = st_q.sign;
    assign ovf_o   = st_q.ovf;
    assign oor_o   = st_q.oor;
    assign err_o   = st_q.err;

    // Output register timing
    p_vld_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(res_o) && $stable(err_o) && $stable(ovf_o)));

    // Unsigned borrow agrees with a magnitude comparison
    p_uns_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && fmt == FMT_UNS && op == OP_SUB) |-> (u_oor == (a_i < b_i)));

    // Two's complement negation overflows only on the most negative pattern
    p_twos_neg_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NEG) |-> (tc_ovf == (a_i == MINPAT)));

    // One's complement inversion cannot overflow
    p_ones_neg_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NEG) |-> !oc_ovf);

    // Sign-magnitude addition of mixed signs cannot overflow
    p_smag_mixed_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD && a_i[N-1] != b_i[N-1]) |-> !sm_ovf);

    // Sign-magnitude negation cannot overflow
    p_smag_neg_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NEG) |-> !sm_ovf);

    // No negative zero leaves either signed-zero format
    p_smag_noneg0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sm_ovf |-> (sm_res != MINPAT));
    p_ones_noneg0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> (oc_res != {N{1'b1}}));

    // Reserved op echoes A with only the error flag
    p_rsv_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == OP_RSV) |=> (err_o && !ovf_o && !oor_o && res_o == $past(a_i)));

    // Flag exclusivity by format
    p_uns_no_ovf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && fmt == FMT_UNS) |=> (!ovf_o && !sign_o));
endmodule

// File: tb/mfmt_arith_test.sv
`timescale 1ns/1ps
module mfmt_arith_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Narrow instance, swept exhaustively
    logic       vld4 = 1'b0;
    logic [1:0] fmt4 = '0;
    logic [1:0] op4  = '0;
    logic [3:0] a4   = '0;
    logic [3:0] b4   = '0;
    logic       ov4_vld, sg4, ovf4, oor4, err4;
    logic [3:0] res4;

    // Wider instance, random operands
    logic       vld8 = 1'b0;
    logic [1:0] fmt8 = '0;
    logic [1:0] op8  = '0;
    logic [7:0] a8   = '0;
    logic [7:0] b8   = '0;
    logic       ov8_vld, sg8, ovf8, oor8, err8;
    logic [7:0] res8;

    mfmt_arith #(.N(4)) uut (
        .clk (clk), .rst_n (rst_n), .in_vld (vld4), .fmt_i (fmt4), .op_i (op4),
        .a_i (a4), .b_i (b4), .out_vld (ov4_vld), .res_o (res4), .sign_o (sg4),
        .ovf_o (ovf4), .oor_o (oor4), .err_o (err4)
    );

    mfmt_arith #(.N(8)) uut_w (
        .clk (clk), .rst_n (rst_n), .in_vld (vld8), .fmt_i (fmt8), .op_i (op8),
        .a_i (a8), .b_i (b8), .out_vld (ov8_vld), .res_o (res8), .sign_o (sg8),
        .ovf_o (ovf8), .oor_o (oor8), .err_o (err8)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int cur_n, cur_f, cur_o, cur_a, cur_b;

    task automatic ck(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s n=%0d fmt=%0d op=%0d a=%0h b=%0h actual=%0h expected=%0h",
                     tag, what, cur_n, cur_f, cur_o, cur_a, cur_b, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic int decode(input int n, input int f, input int v);
        int msb = 1 << (n - 1);
        int mask = (1 << n) - 1;
        case (f)
            1: return (v & msb) != 0 ? -(v & (msb - 1)) : v;
            2: return (v & msb) != 0 ? -((~v) & mask) : v;
            3: return (v & msb) != 0 ? v - (1 << n) : v;
            default: return v;
        endcase
    endfunction

    function automatic int encode(input int n, input int f, input int v);
        int msb = 1 << (n - 1);
        int mask = (1 << n) - 1;
        case (f)
            1: return v < 0 ? (msb | -v) : v;
            2: return v < 0 ? ((~(-v)) & mask) : v;
            default: return v & mask;
        endcase
    endfunction

    // Expected outputs from integer arithmetic on decoded values
    task automatic model(input int n, input int f, input int o, input int a, input int b,
                         output int er, output int es, output int eov, output int eoor,
                         output int eerr, output bit chk);
        int mask = (1 << n) - 1;
        int msb  = 1 << (n - 1);
        int maxv = msb - 1;
        int minv;
        int v;
        er = 0; es = 0; eov = 0; eoor = 0; eerr = 0; chk = 1'b1;
        if (o == 3) begin
            er = a; eerr = 1;
            es = (f != 0 && (a & msb) != 0) ? 1 : 0;
        end else if (f == 0) begin
            if (o == 0) begin
                er = (a + b) & mask; eoor = (a + b) > mask ? 1 : 0;
            end else if (o == 1) begin
                er = (a - b) & mask; eoor = a < b ? 1 : 0;
            end else begin
                er = a; eerr = 1;
            end
        end else begin
            minv = (f == 3) ? -msb : -maxv;
            if (o == 0)      v = decode(n, f, a) + decode(n, f, b);
            else if (o == 1) v = decode(n, f, a) - decode(n, f, b);
            else             v = -decode(n, f, a);
            eov = (v > maxv || v < minv) ? 1 : 0;
            if (eov == 1 && f != 3) chk = 1'b0;
            er = encode(n, f, v);
            es = (er & msb) != 0 ? 1 : 0;
        end
    endtask

    function automatic string tag_of(input int f, input int o);
        if (o == 3) return "R11";
        case (f)
            0: return (o == 2) ? "R4" : "R3";
            1: return (o == 2) ? "R9" : "R8";
            2: return (o == 2) ? "R7" : "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic compare(input int n, input int f, input int o, input int a, input int b,
                           input int r, input int s, input int ov, input int orr,
                           input int er_act, input int vld_act);
        int er, es, eov, eoor, eerr;
        bit chk;
        string tag;
        cur_n = n; cur_f = f; cur_o = o; cur_a = a; cur_b = b;
        model(n, f, o, a, b, er, es, eov, eoor, eerr, chk);
        tag = tag_of(f, o);
        ck("R2", "out_vld", vld_act, 1);
        if (chk) ck(tag, "result", r, er);
        ck(tag, "ovf", ov, eov);
        ck(tag, "oor", orr, eoor);
        ck(tag, "err", er_act, eerr);
        if (chk) ck("R12", "sign", s, es);
        if (chk && (f == 1 || f == 2) && o != 3 && er == 0) ck("R10", "zero", r, 0);
    endtask

    task automatic apply4(input int f, input int o, input int a, input int b);
        fmt4 = 2'(f); op4 = 2'(o); a4 = 4'(a); b4 = 4'(b); vld4 = 1'b1;
        @(negedge clk);
        compare(4, f, o, a, b, int'(res4), int'(sg4), int'(ovf4), int'(oor4),
                int'(err4), int'(ov4_vld));
    endtask

    task automatic apply8(input int f, input int o, input int a, input int b);
        fmt8 = 2'(f); op8 = 2'(o); a8 = 8'(a); b8 = 8'(b); vld8 = 1'b1;
        @(negedge clk);
        compare(8, f, o, a, b, int'(res8), int'(sg8), int'(ovf8), int'(oor8),
                int'(err8), int'(ov8_vld));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int held;
        cur_n = 4; cur_f = 0; cur_o = 0; cur_a = 0; cur_b = 0;
        // R1: reset state
        repeat (3) @(negedge clk);
        ck("R1", "out_vld in reset", int'(ov4_vld), 0);
        ck("R1", "result in reset", int'(res4), 0);
        ck("R1", "flags in reset", int'({sg4, ovf4, oor4, err4}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        ck("R1", "out_vld after reset", int'(ov4_vld), 0);
        ck("R1", "wide result after reset", int'(res8), 0);

        // Exhaustive sweep at N=4
        for (int f = 0; f < 4; f++) begin
            for (int o = 0; o < 3; o++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        apply4(f, o, a, b);
                    end
                end
            end
            for (int a = 0; a < 16; a++) begin
                apply4(f, 3, a, 16 - a - 1);
            end
        end

        // R2: hold while idle
        apply4(3, 0, 3, 2);
        held = int'(res4);
        vld4 = 1'b0; a4 = 4'd7; b4 = 4'd7; op4 = 2'd0;
        @(negedge clk);
        cur_f = 3; cur_o = 0; cur_a = 7; cur_b = 7;
        ck("R2", "out_vld idle", int'(ov4_vld), 0);
        ck("R2", "result held", int'(res4), held);
        ck("R2", "held value", held, 5);
        @(negedge clk);
        ck("R2", "result still held", int'(res4), 5);

        // Wide corners
        apply8(3, 2, 8'h80, 0);
        apply8(3, 1, 8'h00, 8'h80);
        apply8(1, 0, 8'h7F, 8'h7F);
        apply8(1, 0, 8'hFF, 8'h7F);
        apply8(2, 0, 8'h80, 8'hFF);
        apply8(2, 2, 8'h00, 0);
        apply8(0, 1, 8'h00, 8'h01);
        apply8(1, 2, 8'h00, 0);

        // Random operands at N=8
        for (int i = 0; i < 4000; i++) begin
            apply8(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                   int'($urandom_range(255, 0)), int'($urandom_range(255, 0)));
        end
        vld8 = 1'b0;
        @(negedge clk);
        ck("R2", "wide out_vld idle", int'(ov8_vld), 0);

        finish_run();
    end
endmodule